// File: doc/BRIEF.md
# Strobe-Decoded Shadow Store/Recall Controller

This controller sits in front of a byte-wide static array that has a non-volatile shadow copy. It samples four active-low strobes on every clock: select, write strobe, output strobe and a shadow strobe. From these it derives array read and write enables and an output-drive enable for the data bus. It also starts the two bulk transfers: a store copies the array into the shadow copy, and a recall copies the shadow copy back into the array.

A transfer is armed only by a fresh high-to-low edge on the shadow strobe. It starts once the strobes reach the store or recall pattern. The controller then sends a single-cycle request toward the array and holds `busy` for a fixed number of clocks. During that interval it ignores every strobe and keeps the data bus undriven. A supply-good input blocks new stores and cuts short a store that is already running. Recalls do not depend on it. When the interval ends, whatever read or write pattern is then on the strobes takes effect in that same cycle.

Top module: `nv_shadow_ctl`

## Requirements
- R1: While not busy, `rd_en` and `dq_oe` are 1 exactly when `ce_n`=0, `oe_n`=0, `we_n`=1 and `nve_n`=1. Both follow the strobes combinationally.
- R2: While not busy, `wr_en` is 1 exactly when `ce_n`=0, `we_n`=0 and `nve_n`=1.
- R3: With `ce_n`=1, or with all four strobes at 0, no enable is raised and no transfer starts.
- R4: When armed and not busy, a clock edge that samples `ce_n`=0, `we_n`=0, `oe_n`=1, `nve_n`=0 with `supply_ok`=1 makes `store_req` 1 for exactly one cycle after that edge. `busy` rises in that same cycle.
- R5: When armed and not busy, a clock edge that samples `ce_n`=0, `oe_n`=0, `we_n`=1, `nve_n`=0 makes `recall_req` 1 for exactly one cycle after that edge, with `busy` rising. `store_req` and `recall_req` are never 1 together.
- R6: Arming requires a high-to-low transition of `nve_n` sampled on two consecutive edges. `nve_n` held low from reset, or held low through the end of a transfer, starts nothing.
- R7: `busy` stays 1 for STORE_CYCLES cycles for a store and RECALL_CYCLES cycles for a recall. While `busy` is 1, `rd_en`, `wr_en` and `dq_oe` are 0 and no new request is issued.
- R8: A store attempt sampled with `supply_ok`=0 is refused and uses up the arming. If `supply_ok` is sampled 0 during a store, `busy` falls in the next cycle. Recalls ignore `supply_ok`.
- R9: In the first cycle after `busy` falls, the read or write decode of the current strobes is already in effect.
- R10: Arming persists while `nve_n` stays low. A fall taken with `ce_n`=1 starts a transfer once `ce_n` later goes low in the store or recall pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Select strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| nve_n | input | 1 | Shadow-transfer strobe, active low |
| supply_ok | input | 1 | Supply-good indication from an external sensor |
| rd_en | output | 1 | Array read enable |
| wr_en | output | 1 | Array write enable |
| dq_oe | output | 1 | Data bus drive enable |
| store_req | output | 1 | One-cycle request: copy array into shadow |
| recall_req | output | 1 | One-cycle request: copy shadow into array |
| busy | output | 1 | A timed transfer is in progress |

## Verification
The hardest cases to reach are the ones where a transfer must not start even though the strobes show a valid store or recall pattern. These are the pattern held low from reset, the pattern still held when a transfer ends, and a store refused for low supply and then retried with the supply restored. The stimulus reaches each of these by holding `nve_n` low across reset, across the whole busy interval, and across a change in `supply_ok`. All sixteen strobe patterns are applied from an idle, disarmed state and checked against an arithmetic decode. Timed runs count busy cycles and overlay read and recall patterns during the interval to confirm they are ignored.

// File: rtl/nv_shadow_ctl.sv
module nv_shadow_ctl #(
  parameter int STORE_CYCLES  = 5000,
  parameter int RECALL_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic nve_n,
  input  logic supply_ok,
  output logic rd_en,
  output logic wr_en,
  output logic dq_oe,
  output logic store_req,
  output logic recall_req,
  output logic busy
);
  localparam int LMAX = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CW = $clog2(LMAX + 1);
  localparam logic [CW-1:0] ST_LAST = CW'(STORE_CYCLES - 1);
  localparam logic [CW-1:0] RC_LAST = CW'(RECALL_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic is_store, nve_prev, armed;

  wire sel        = !ce_n;
  wire dec_read   = sel & !oe_n &  we_n &  nve_n;
  wire dec_write  = sel & !we_n &  nve_n;
  wire dec_store  = sel & !we_n &  oe_n & !nve_n;
  wire dec_recall = sel & !oe_n &  we_n & !nve_n;
  wire nve_fell   = nve_prev & !nve_n;
  wire trig       = !busy & (armed | nve_fell);
  wire go_store   = trig & dec_store & supply_ok;
  wire go_recall  = trig & dec_recall;
  wire refused    = trig & dec_store & !supply_ok;
  wire last       = cnt == (is_store ? ST_LAST : RC_LAST);

  assign rd_en = !busy & dec_read;
  assign wr_en = !busy & dec_write;
  assign dq_oe = rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nve_prev   <= 1'b0;
      armed      <= 1'b0;
      busy       <= 1'b0;
      is_store   <= 1'b0;
      cnt        <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      nve_prev   <= nve_n;
      store_req  <= go_store;
      recall_req <= go_recall;
      if (busy) begin
        armed <= 1'b0;
        if ((is_store && !supply_ok) || last) busy <= 1'b0;
        else cnt <= cnt + 1'b1;
      end else if (go_store || go_recall) begin
        busy     <= 1'b1;
        cnt      <= '0;
        is_store <= go_store;
        armed    <= 1'b0;
      end else if (refused) begin
        armed <= 1'b0;
      end else begin
        armed <= !nve_n & (armed | nve_fell);
      end
    end
  end
endmodule

// File: rtl/nv_shadow_ctl_chk.sv
module nv_shadow_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic nve_n,
  input logic supply_ok,
  input logic rd_en,
  input logic wr_en,
  input logic dq_oe,
  input logic store_req,
  input logic recall_req,
  input logic busy,
  input logic is_store
);
  p_store_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);
  p_store_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> busy);
  p_recall_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);
  p_req_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));
  p_nve_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> $past(!nve_n));
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (store_req || recall_req));
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(rd_en || wr_en || dq_oe));
  p_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> $past(supply_ok));
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_store && !supply_ok) |=> !busy);
endmodule

bind nv_shadow_ctl nv_shadow_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nve_n(nve_n), .supply_ok(supply_ok),
  .rd_en(rd_en), .wr_en(wr_en), .dq_oe(dq_oe), .store_req(store_req),
  .recall_req(recall_req), .busy(busy), .is_store(is_store)
);

// File: tb/tb_nv_shadow_ctl.sv
module tb_nv_shadow_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int ST = 12;
  localparam int RC = 5;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, we_n = 1, oe_n = 1, nve_n = 0, supply_ok = 1;
  logic rd_en, wr_en, dq_oe, store_req, recall_req, busy;
  int checks = 0, fails = 0;
  bit finished = 0;

  nv_shadow_ctl #(.STORE_CYCLES(ST), .RECALL_CYCLES(RC)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .nve_n(nve_n), .supply_ok(supply_ok), .rd_en(rd_en), .wr_en(wr_en),
    .dq_oe(dq_oe), .store_req(store_req), .recall_req(recall_req), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobes(logic c, logic w, logic o, logic n);
    ce_n = c; we_n = w; oe_n = o; nve_n = n;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    strobes(0, 0, 1, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    chk("R6 reset busy", busy, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R6 powerup nve low no store", store_req | busy, 0);
    end

    for (int c = 0; c < 16; c++) begin
      logic ce, we, oe, nv;
      {ce, we, oe, nv} = 4'(c);
      @(negedge clk); strobes(1, 1, 1, 1); supply_ok = 1;
      @(negedge clk); strobes(ce, we, oe, nv);
      #1;
      chk("R1 read decode", rd_en, int'(!ce & !oe & we & nv));
      chk("R1 drive decode", dq_oe, int'(!ce & !oe & we & nv));
      chk("R2 write decode", wr_en, int'(!ce & !we & nv));
      if (ce || c == 0) chk("R3 deselect/all-low", rd_en | wr_en, 0);
      @(negedge clk);
      chk("R4 store start", store_req, int'(!ce & !we & oe & !nv));
      chk("R5 recall start", recall_req, int'(!ce & !oe & we & !nv));
      if (ce || c == 0) chk("R3 no transfer", busy, 0);
      strobes(1, 1, 1, 1);
      @(negedge clk);
      chk("R4 R5 one-cycle request", store_req | recall_req, 0);
      wait_idle();
    end

    // store duration, ignored strobes, read right after
    @(negedge clk); strobes(1, 1, 1, 1);
    @(negedge clk); strobes(0, 0, 1, 0);
    @(negedge clk);
    chk("R4 store_req", store_req, 1);
    chk("R4 busy with req", busy, 1);
    n = 1;
    strobes(0, 1, 0, 1);
    #1 chk("R7 read blocked", rd_en | dq_oe, 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!busy) break;
      n++;
      if (n == 4) strobes(0, 1, 0, 0);
      if (n == 6) strobes(0, 1, 0, 1);
      #1 chk("R7 io quiet and no request", rd_en | wr_en | recall_req, 0);
    end
    chk("R7 store length", n, ST);
    #1 chk("R9 read right after", rd_en, 1);

    // store condition held through completion
    @(negedge clk); strobes(1, 1, 1, 1);
    @(negedge clk); strobes(0, 0, 1, 0);
    @(negedge clk); chk("R4 held start", store_req, 1);
    wait_idle();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R6 no retrigger when held", store_req | busy, 0);
    end
    strobes(0, 0, 1, 1);
    @(negedge clk); #1 chk("R9 write decode", wr_en, 1);
    strobes(0, 0, 1, 0);
    @(negedge clk); chk("R6 fresh fall restarts", store_req, 1);
    wait_idle();

    // recall length with supply low
    @(negedge clk); strobes(1, 1, 1, 1); supply_ok = 0;
    @(negedge clk); strobes(0, 1, 0, 0);
    @(negedge clk);
    chk("R5 recall_req", recall_req, 1);
    n = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!busy) break;
      n++;
    end
    chk("R8 R7 recall length ignores supply", n, RC);

    // refused store
    @(negedge clk); strobes(1, 1, 1, 1); supply_ok = 0;
    @(negedge clk); strobes(0, 0, 1, 0);
    @(negedge clk); chk("R8 refused", store_req | busy, 0);
    supply_ok = 1;
    @(negedge clk);
    @(negedge clk); chk("R8 refusal consumes arming", store_req | busy, 0);

    // arm with ce high, then select
    @(negedge clk); strobes(1, 1, 1, 1);
    @(negedge clk); strobes(1, 0, 1, 0);
    @(negedge clk); chk("R10 no start deselected", busy, 0);
    strobes(0, 0, 1, 0);
    @(negedge clk); chk("R10 armed start", store_req, 1);
    @(negedge clk); supply_ok = 0;
    @(negedge clk); chk("R8 abort", busy, 0);
    supply_ok = 1;
    @(negedge clk); chk("R8 no restart after abort", busy, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule